// File: doc/BRIEF.md
# Keyed Reset-Pulse Generator

This block owns the configuration of a watchdog's external reset output and produces the reset pulse itself. A write port loads the configuration register. An expiry trigger from the watchdog counter starts a pulse. The pulse has a programmable length in clock cycles, a selectable asserted level, and a selectable drive style (push-pull or open-drain). Open-drain drive is modelled as a separate output-enable signal next to the output level.

The asserted level and the drive style cannot be changed by writing their bits directly. A write changes one of them only when its top byte carries one of four key values. Every other top byte leaves both attributes alone. The pulse-width field is loaded on every write, and its width depends on the variant: 8 bits in the older variant and 20 bits in the newer one. Key decoding exists only in the newer variant, which a parameter selects.

Top module: `wdt_rst_pulse`

## Requirements
- R1: After reset the register reads 0x000000FF (bit 31 = 0, bit 30 = 0, width field 0xFF), `rst_out` is high and `rst_oe` is low.
- R2: In the newer variant, a write with top byte 0xA5 sets bit 31 (active-high output). A write with top byte 0x5A clears bit 31 (active-low output).
- R3: In the newer variant, a write with top byte 0xA8 sets bit 30 (push-pull drive). A write with top byte 0x8A clears bit 30 (open-drain drive).
- R4: A write whose top byte is none of the four keys leaves bits 31 and 30 unchanged. The bits between bit 30 and the width field always read 0.
- R5: In the older variant no key is decoded, so bits 31 and 30 stay 0 whatever is written.
- R6: Every write loads data bits [FW-1:0] into the width field, where FW is 20 in the newer variant and 8 in the older one. The other data bits below the top byte are discarded.
- R7: A trigger that is sampled while no pulse is running asserts the output from the next cycle for (width field + 1) cycles.
- R8: A trigger that arrives while a pulse is running is ignored. The running pulse keeps its length and no second pulse follows it.
- R9: While asserted, `rst_out` equals bit 31. While idle, `rst_out` is the inverse of bit 31.
- R10: With bit 30 set, `rst_oe` is 1 at all times. With bit 30 clear, `rst_oe` is 1 only while the pulse is asserted and bit 31 is 0 (driving low).
- R11: The pulse length is fixed by the width field at the cycle the trigger is accepted. A write during the pulse changes the register but not the running pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the configuration register |
| wr_data | input | REG_W | Write data: key byte on top, width field at the bottom |
| trig | input | 1 | Expiry trigger from the watchdog counter |
| cfg_rd | output | REG_W | Current register contents |
| rst_out | output | 1 | Reset output level |
| rst_oe | output | 1 | Output enable for the reset pad (low means released in open-drain mode) |

## Verification
The hardest situations to reach from the ports are a second trigger, or a width rewrite, that lands while a pulse is already running. To reach them, the stimulus programs a short width, fires once, and then fires again or writes a new width two cycles later. A scoreboard measures each pulse and compares its length with the one queued when the first trigger was accepted. A stray second pulse shows up as a pulse that has no queued entry. The attribute keys are also interleaved with non-key top bytes that carry junk in the discarded bits, which shows that only the four exact byte values move the attributes.

// File: rtl/wdtrp_pkg.sv
package wdtrp_pkg;
   localparam int KEY_W = 8;

   localparam logic [KEY_W-1:0] KEY_LEVEL_HIGH = 8'hA5;
   localparam logic [KEY_W-1:0] KEY_LEVEL_LOW  = 8'h5A;
   localparam logic [KEY_W-1:0] KEY_DRIVE_PP   = 8'hA8;
   localparam logic [KEY_W-1:0] KEY_DRIVE_OD   = 8'h8A;

   typedef struct packed {
      logic level_set;
      logic level_clr;
      logic drive_set;
      logic drive_clr;
   } attr_cmd_t;
endpackage

// File: rtl/wdtrp_key_decode.sv
module wdtrp_key_decode
   import wdtrp_pkg::*;
#(
   parameter bit KEYS_ON = 1'b1
) (
   input  logic             wr_en,
   input  logic [KEY_W-1:0] key,
   output attr_cmd_t        cmd
);
   generate
      if (KEYS_ON) begin : g_keyed
         always_comb begin
            cmd = '0;
            if (wr_en) begin
               case (key)
                  KEY_LEVEL_HIGH: cmd.level_set = 1'b1;
                  KEY_LEVEL_LOW:  cmd.level_clr = 1'b1;
                  KEY_DRIVE_PP:   cmd.drive_set = 1'b1;
                  KEY_DRIVE_OD:   cmd.drive_clr = 1'b1;
                  default:        cmd = '0;
               endcase
            end
         end
      end else begin : g_plain
         logic unused_key;
         assign unused_key = ^{wr_en, key};
         assign cmd = '0;
      end
   endgenerate
endmodule

// File: rtl/wdtrp_cfg_reg.sv
module wdtrp_cfg_reg
   import wdtrp_pkg::*;
#(
   parameter int          REG_W     = 32,
   parameter int          FW        = 20,
   parameter int unsigned RST_WIDTH = 255
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [FW-1:0]    wr_width,
   input  attr_cmd_t        cmd,
   output logic             level_hi,
   output logic             push_pull,
   output logic [FW-1:0]    width,
   output logic [REG_W-1:0] cfg_rd
);
   localparam int GAP_W = REG_W - 2 - FW;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_hi  <= 1'b0;
         push_pull <= 1'b0;
         width     <= FW'(RST_WIDTH);
      end else begin
         if (wr_en) width <= wr_width;
         if (cmd.level_set)      level_hi <= 1'b1;
         else if (cmd.level_clr) level_hi <= 1'b0;
         if (cmd.drive_set)      push_pull <= 1'b1;
         else if (cmd.drive_clr) push_pull <= 1'b0;
      end
   end

   assign cfg_rd = {level_hi, push_pull, {GAP_W{1'b0}}, width};
endmodule

// File: rtl/wdtrp_pulse_gen.sv
module wdtrp_pulse_gen #(
   parameter int FW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          trig,
   input  logic [FW-1:0] width,
   input  logic          level_hi,
   input  logic          push_pull,
   output logic          rst_out,
   output logic          rst_oe,
   output logic          busy
);
   logic [FW-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         remain <= '0;
      end else if (!busy) begin
         if (trig) begin
            busy   <= 1'b1;
            remain <= width;
         end
      end else if (remain == '0) begin
         busy <= 1'b0;
      end else begin
         remain <= remain - 1'b1;
      end
   end

   assign rst_out = busy ? level_hi : ~level_hi;
   assign rst_oe  = push_pull | (busy & ~level_hi);
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse
   import wdtrp_pkg::*;
#(
   parameter int          REG_W         = 32,
   parameter bit          NEWER_VARIANT = 1'b1,
   parameter int          NARROW_FW     = 8,
   parameter int          WIDE_FW       = 20,
   parameter int unsigned RST_WIDTH     = 255
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             trig,
   output logic [REG_W-1:0] cfg_rd,
   output logic             rst_out,
   output logic             rst_oe
);
   localparam int FW      = NEWER_VARIANT ? WIDE_FW : NARROW_FW;
   localparam int KEY_LSB = REG_W - KEY_W;

   generate
      if (FW >= KEY_LSB) begin : g_bad_width
         $error("width field overlaps the key byte");
      end
      if (NARROW_FW > WIDE_FW) begin : g_bad_order
         $error("narrow width field wider than wide one");
      end
      if (RST_WIDTH >= (1 << NARROW_FW)) begin : g_bad_reset
         $error("reset width does not fit the narrow field");
      end
   endgenerate

   attr_cmd_t     cmd;
   logic          level_hi;
   logic          push_pull;
   logic [FW-1:0] width;
   logic          pulse_busy;
   logic          unused_mid;

   assign unused_mid = ^wr_data[KEY_LSB-1:FW];

   wdtrp_key_decode #(.KEYS_ON(NEWER_VARIANT)) u_keys (
      .wr_en (wr_en),
      .key   (wr_data[REG_W-1:KEY_LSB]),
      .cmd   (cmd)
   );

   wdtrp_cfg_reg #(.REG_W(REG_W), .FW(FW), .RST_WIDTH(RST_WIDTH)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_width  (wr_data[FW-1:0]),
      .cmd       (cmd),
      .level_hi  (level_hi),
      .push_pull (push_pull),
      .width     (width),
      .cfg_rd    (cfg_rd)
   );

   wdtrp_pulse_gen #(.FW(FW)) u_pulse (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (trig),
      .width     (width),
      .level_hi  (level_hi),
      .push_pull (push_pull),
      .rst_out   (rst_out),
      .rst_oe    (rst_oe),
      .busy      (pulse_busy)
   );
endmodule

// File: rtl/wdt_rst_pulse_chk.sv
module wdt_rst_pulse_chk #(
   parameter int REG_W = 32,
   parameter int FW    = 20,
   parameter bit NEWER = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [REG_W-1:0] wr_data,
   input logic             trig,
   input logic [REG_W-1:0] cfg_rd,
   input logic             rst_out,
   input logic             rst_oe,
   input logic             busy
);
   logic [7:0]    kb;
   logic          is_key;
   logic [FW:0]   run_len;
   logic [FW-1:0] want;
   logic          unused_chk;

   assign kb         = wr_data[REG_W-1 -: 8];
   assign is_key     = (kb == 8'hA5) || (kb == 8'h5A) || (kb == 8'hA8) || (kb == 8'h8A);
   assign unused_chk = ^wr_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_len <= '0;
         want    <= '0;
      end else begin
         run_len <= busy ? run_len + 1'b1 : '0;
         if (!busy && trig) want <= cfg_rd[FW-1:0];
      end
   end

   a_r2_level_set: assert property (@(posedge clk) disable iff (!rst_n)
      NEWER && wr_en && kb == 8'hA5 |=> cfg_rd[REG_W-1]);
   a_r2_level_clr: assert property (@(posedge clk) disable iff (!rst_n)
      NEWER && wr_en && kb == 8'h5A |=> !cfg_rd[REG_W-1]);
   a_r3_drive_set: assert property (@(posedge clk) disable iff (!rst_n)
      NEWER && wr_en && kb == 8'hA8 |=> cfg_rd[REG_W-2]);
   a_r3_drive_clr: assert property (@(posedge clk) disable iff (!rst_n)
      NEWER && wr_en && kb == 8'h8A |=> !cfg_rd[REG_W-2]);
   a_r4_attr_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && is_key) |=> $stable(cfg_rd[REG_W-1 -: 2]));
   a_r5_no_keys_old: assert property (@(posedge clk) disable iff (!rst_n)
      !NEWER |-> cfg_rd[REG_W-1 -: 2] == 2'b00);
   a_r6_width_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cfg_rd[FW-1:0] == $past(wr_data[FW-1:0]));
   a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && trig |=> busy && rst_out == cfg_rd[REG_W-1]);
   // R8, R11: a pulse ends exactly width+1 cycles after the width seen at acceptance
   a_r7_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> run_len == {1'b0, want} + 1'b1);
   a_r9_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> rst_out != cfg_rd[REG_W-1]);
   a_r10_push_pull: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rd[REG_W-2] |-> rst_oe);
   a_r10_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rd[REG_W-2] && rst_oe |-> busy && !rst_out);
endmodule

bind wdt_rst_pulse wdt_rst_pulse_chk #(
   .REG_W (REG_W),
   .FW    (FW),
   .NEWER (NEWER_VARIANT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .trig    (trig),
   .cfg_rd  (cfg_rd),
   .rst_out (rst_out),
   .rst_oe  (rst_oe),
   .busy    (pulse_busy)
);

// File: tb/wdt_rst_pulse_tb_top.sv
module wdt_rst_pulse_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        trig = 1'b0;
   logic [31:0] cfg_rd;
   logic        rst_out, rst_oe;

   logic        o_wr_en = 1'b0;
   logic [31:0] o_wr_data = '0;
   logic [31:0] o_cfg;
   logic        o_out, o_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      int    len;
      string tag;
   } pulse_t;
   pulse_t exp_q[$];

   logic mon_en = 1'b0;
   logic exp_pol = 1'b0;
   logic exp_oe = 1'b0;

   always #5 clk = ~clk;

   wdt_rst_pulse dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .trig(trig),
      .cfg_rd(cfg_rd), .rst_out(rst_out), .rst_oe(rst_oe)
   );

   wdt_rst_pulse #(.NEWER_VARIANT(1'b0)) dut_old_i (
      .clk(clk), .rst_n(rst_n), .wr_en(o_wr_en), .wr_data(o_wr_data), .trig(1'b0),
      .cfg_rd(o_cfg), .rst_out(o_out), .rst_oe(o_oe)
   );

   task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic chk1(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic wr_old(input logic [31:0] d);
      @(negedge clk); o_wr_en = 1'b1; o_wr_data = d;
      @(negedge clk); o_wr_en = 1'b0; o_wr_data = '0;
   endtask

   task automatic fire(input int len, input string tag);
      pulse_t it;
      it.len = len;
      it.tag = tag;
      exp_q.push_back(it);
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
   endtask

   task automatic settle();
      wait (exp_q.size() == 0);
      repeat (12) @(negedge clk);
      mon_en = 1'b0;
   endtask

   // scoreboard monitor: measures each asserted stretch and pops its expectation
   initial begin
      int     run;
      bit     oe_bad;
      pulse_t it;
      run = 0;
      oe_bad = 1'b0;
      forever begin
         @(negedge clk); #1;
         if (mon_en) begin
            if (rst_out === exp_pol) begin
               run++;
               if (rst_oe !== exp_oe) oe_bad = 1'b1;
            end else if (run > 0) begin
               if (exp_q.size() == 0) begin
                  checks++; errors++;
                  $display("FAIL R8: unexpected pulse of %0d cycles, expected none", run);
               end else begin
                  it = exp_q.pop_front();
                  checks++;
                  if (run != it.len) begin
                     errors++;
                     $display("FAIL %s: pulse length actual %0d expected %0d", it.tag, run, it.len);
                  end
                  checks++;
                  if (oe_bad) begin
                     errors++;
                     $display("FAIL R10 (%s): rst_oe actual differs during pulse, expected %0b", it.tag, exp_oe);
                  end
               end
               run = 0;
               oe_bad = 1'b0;
            end
         end else begin
            run = 0;
            oe_bad = 1'b0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk32("R1 reset value", cfg_rd, 32'h0000_00FF);
      chk1("R1 idle output", rst_out, 1'b1);
      chk1("R1 idle enable", rst_oe, 1'b0);
      chk32("R1 reset value old", o_cfg, 32'h0000_00FF);

      // R2, R6, R9
      wr(32'hA500_0003);
      chk32("R2 level set", cfg_rd, 32'h8000_0003);
      chk1("R9 idle low for active-high", rst_out, 1'b0);
      wr(32'h5A00_0005);
      chk32("R2 level clear", cfg_rd, 32'h0000_0005);
      chk1("R9 idle high for active-low", rst_out, 1'b1);

      // R3, R10
      wr(32'hA800_0002);
      chk32("R3 drive set", cfg_rd, 32'h4000_0002);
      chk1("R10 push-pull enable", rst_oe, 1'b1);
      wr(32'h8A00_0002);
      chk32("R3 drive clear", cfg_rd, 32'h0000_0002);
      chk1("R10 open-drain idle enable", rst_oe, 1'b0);

      // R4, R6: non-key top bytes, junk in discarded bits
      wr(32'hA500_0000);
      wr(32'h12FA_BCDE);
      chk32("R4 R6 non-key keeps attr", cfg_rd, 32'h800A_BCDE);
      wr(32'hA53F_FFFF & 32'h00FF_FFFF | 32'h5B00_0003);
      chk32("R4 near-key byte ignored", cfg_rd, 32'h800F_FFFF);
      wr(32'h5A00_0003);
      chk32("R2 back to active-low", cfg_rd, 32'h0000_0003);

      // R7: active-low open-drain, width 3
      exp_pol = 1'b0; exp_oe = 1'b1; mon_en = 1'b1;
      fire(4, "R7 width3");
      chk1("R7 asserted next cycle", rst_out, 1'b0);
      settle();

      // R7: width 0 gives a single cycle
      wr(32'h0000_0000);
      mon_en = 1'b1;
      fire(1, "R7 width0");
      settle();

      // R8: retrigger during a pulse
      wr(32'h0000_0005);
      mon_en = 1'b1;
      fire(6, "R8 retrigger");
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      settle();

      // R11: width rewritten during the pulse
      wr(32'h0000_0006);
      mon_en = 1'b1;
      fire(7, "R11 latched width");
      wr(32'h0000_0001);
      settle();
      chk32("R11 register updated", cfg_rd, 32'h0000_0001);

      // R9, R10: active-high push-pull
      wr(32'hA500_0002);
      wr(32'hA800_0002);
      exp_pol = 1'b1; exp_oe = 1'b1; mon_en = 1'b1;
      fire(3, "R9 active-high push-pull");
      settle();

      // R10: active-high open-drain never enables
      wr(32'h8A00_0002);
      exp_pol = 1'b1; exp_oe = 1'b0; mon_en = 1'b1;
      fire(3, "R10 active-high open-drain");
      settle();

      // R5, R6 on the older variant
      wr_old(32'hA512_3456);
      chk32("R5 R6 old variant level key", o_cfg, 32'h0000_0056);
      wr_old(32'hA800_0000);
      chk32("R5 old variant drive key", o_cfg, 32'h0000_0000);
      chk1("R5 old variant enable", o_oe, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule